// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Full and Near-Empty Flags

This block is the threshold-flag logic of an asynchronous FIFO, wrapped around a small dual-clock store so that the flags can be exercised. The write side raises an active-low near-full flag, `paf_n`, in the write-clock domain. The read side raises an active-low near-empty flag, `pae_n`, in the read-clock domain. Each side computes the fill level from its own binary pointer and from the other side's pointer. The other side's pointer arrives as Gray code through a chain of synchronizer flops. A stale copy of the far pointer can only overstate the level seen on the write side, and can only understate the level seen on the read side. Because of this, each flag asserts on the very edge that crosses its threshold, and releases a few cycles after the opposite port has acted.

Two offset inputs set the thresholds. The near-full offset `full_ofs` places the near-full threshold that many words below the capacity. The near-empty offset `empty_ofs` places the near-empty threshold that many words above empty. The output organisation is picked by the `fwft_sel` pin and is captured once after reset:
- **Standard mode:** a read request delivers data one read clock later, with a one-cycle valid pulse.
- **Fall-through mode:** the head word waits in an output register without any request. That register adds one word to the capacity and moves the near-empty threshold up by one.

Top module: `almost_flag_fifo`

## Requirements
- R1: While reset is held and until the first access after it: paf_n=1, pae_n=0, full=0, empty=1, rd_valid=0.
- R2: Once both clocks have settled after the last access, paf_n is 0 exactly when the words held plus full_ofs is at least the capacity D. D is 2^AW in standard mode and 2^AW+1 in fall-through mode. Words held counts the fall-through output register when it is occupied.
- R3: Once settled, pae_n is 0 exactly when the words held are at most empty_ofs (standard mode) or at most empty_ofs+1 (fall-through mode).
- R4: Assertion is never late. paf_n is already 0 at the write-clock edge that accepts the write bringing the level to its threshold. pae_n is already 0 at the read-clock edge that accepts the read bringing the level to its threshold.
- R5: After the opposite port moves the level out of a flag's region, that flag returns to 1 within 5 cycles of its own clock. Each pointer that crosses domains changes at most one bit per edge.
- R6: full is 1 when the words held reach D. A write request while full=1 stores nothing. A read request with no word available delivers nothing. empty is 1 when no word is held.
- R7: Data leaves in write order. In standard mode, the word appears on rd_data one read-clock edge after an accepted read, with rd_valid high for exactly that cycle. In fall-through mode, rd_data shows the head word with rd_valid=1 whenever a word is held, and an accepted read (rd_en with rd_valid=1) advances to the next word.
- R8: fwft_sel (1 = fall-through, 0 = standard) is captured at the first edge of each clock after reset release. Later changes of the pin have no effect on capacity, thresholds or read behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Output mode, captured after reset: 1 fall-through, 0 standard |
| full_ofs | input | AW+1 | Near-full offset m, held static |
| empty_ofs | input | AW+1 | Near-empty offset n, held static |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| full | output | 1 | No room for another word (write clock) |
| paf_n | output | 1 | Near-full flag, active low (write clock) |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read data / head word |
| rd_valid | output | 1 | Standard: read-data pulse; fall-through: head word present |
| empty | output | 1 | No word available (read clock) |
| pae_n | output | 1 | Near-empty flag, active low (read clock) |

## Verification
A pointer that slips by one shows up first as a near-full or near-empty flag that disagrees with the settled level, at one particular step of the fill-and-drain sweep. It also shows up as a word that is repeated or skipped at the read port. A wrong capacity or mode capture shifts every threshold by one word. A synchronizer or Gray-conversion fault shows up as a flag that does not release within five own-clock cycles, or as a level that is wrong right after an access. The bench therefore checks every level from empty to full and back, for several offset pairs in both modes, both on the access edge and after settling.

// File: rtl/afl_pkg.sv
`timescale 1ns/1ps
package afl_pkg;

  // binary to reflected Gray code
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // level within ofs words of capacity cap
  function automatic logic near_full(input logic [31:0] lvl, input logic [31:0] cap,
                                     input logic [31:0] ofs);
    return (lvl + ofs) >= cap;
  endfunction

  // level at or below ofs (+1 when the output register adds a slot)
  function automatic logic near_empty(input logic [31:0] lvl, input logic [31:0] ofs,
                                      input logic fw);
    return lvl <= (ofs + 32'(fw));
  endfunction

endpackage

// File: rtl/afl_sync.sv
`timescale 1ns/1ps
module afl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/afl_wside.sv
`timescale 1ns/1ps
module afl_wside import afl_pkg::*; #(
  parameter int AW = 4,
  parameter int PW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [AW:0]   full_ofs,
  input  logic [PW-1:0] cons_gray_s,
  input  logic [PW-1:0] mem_gray_s,
  output logic [PW-1:0] wr_gray,
  output logic [AW-1:0] wr_addr,
  output logic          wr_take,
  output logic          full,
  output logic          paf_n
);
  localparam int DEPTH = 1 << AW;

  logic          arm, mode_q;
  logic [PW-1:0] wbin, wbin_nxt, cons_bin, mem_bin;
  logic [PW-1:0] tot_nxt, mem_nxt, mem_now, cap;

  always_comb begin
    cons_bin = PW'(from_gray(32'(cons_gray_s)));
    mem_bin  = PW'(from_gray(32'(mem_gray_s)));
    wr_take  = wr_en && !full;
    wbin_nxt = wbin + PW'(wr_take);
    tot_nxt  = wbin_nxt - cons_bin;
    mem_nxt  = wbin_nxt - mem_bin;
    mem_now  = wbin - mem_bin;
    cap      = PW'(DEPTH) + PW'(mode_q);
  end

  assign wr_addr = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm     <= 1'b1;
      mode_q  <= 1'b0;
      wbin    <= '0;
      wr_gray <= '0;
      full    <= 1'b0;
      paf_n   <= 1'b1;
    end else begin
      arm     <= 1'b0;
      if (arm) mode_q <= mode_sel;
      wbin    <= wbin_nxt;
      wr_gray <= PW'(to_gray(32'(wbin_nxt)));
      full    <= (tot_nxt >= cap) || (mem_nxt >= PW'(DEPTH));
      paf_n   <= !near_full(32'(tot_nxt), 32'(cap), 32'(full_ofs));
    end
  end

  // R6
  mem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_now <= PW'(DEPTH));

  // R5
  wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R8
  wmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(mode_q));
endmodule

// File: rtl/afl_rside.sv
`timescale 1ns/1ps
module afl_rside import afl_pkg::*; #(
  parameter int AW = 4,
  parameter int PW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          rd_en,
  input  logic [AW:0]   empty_ofs,
  input  logic [PW-1:0] wr_gray_s,
  output logic [PW-1:0] cons_gray,
  output logic [PW-1:0] mem_gray,
  output logic [AW-1:0] rd_addr,
  output logic          load,
  output logic          rd_valid,
  output logic          empty,
  output logic          pae_n
);
  localparam int DEPTH = 1 << AW;

  logic          arm, mode_q, rd_hit, ov_nxt, empty_nxt;
  logic [PW-1:0] mbin, mbin_nxt, wbin_s, mcnt, held_nxt, cbin_nxt, tot_nxt;

  always_comb begin
    wbin_s = PW'(from_gray(32'(wr_gray_s)));
    mcnt   = wbin_s - mbin;
    if (mode_q) begin
      // output register holds the head word; refill whenever it frees up
      rd_hit = rd_en && rd_valid;
      load   = (mcnt != '0) && (!rd_valid || rd_hit);
      ov_nxt = load || (rd_valid && !rd_hit);
    end else begin
      rd_hit = rd_en && (mcnt != '0);
      load   = rd_hit;
      ov_nxt = rd_hit;
    end
    mbin_nxt  = mbin + PW'(load);
    held_nxt  = PW'(mode_q && ov_nxt);
    cbin_nxt  = mbin_nxt - held_nxt;
    tot_nxt   = (wbin_s - mbin_nxt) + held_nxt;
    empty_nxt = mode_q ? !ov_nxt : (wbin_s == mbin_nxt);
  end

  assign rd_addr = mbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm       <= 1'b1;
      mode_q    <= 1'b0;
      mbin      <= '0;
      cons_gray <= '0;
      mem_gray  <= '0;
      rd_valid  <= 1'b0;
      empty     <= 1'b1;
      pae_n     <= 1'b0;
    end else begin
      arm       <= 1'b0;
      if (arm) mode_q <= mode_sel;
      mbin      <= mbin_nxt;
      cons_gray <= PW'(to_gray(32'(cbin_nxt)));
      mem_gray  <= PW'(to_gray(32'(mbin_nxt)));
      rd_valid  <= ov_nxt;
      empty     <= empty_nxt;
      pae_n     <= !near_empty(32'(tot_nxt), 32'(empty_ofs), mode_q);
    end
  end

  // R6
  rd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt <= PW'(DEPTH));

  // R3
  empty_pae_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pae_n);

  // R5
  cgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cons_gray ^ $past(cons_gray)) <= 1);

  // R8
  rmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(mode_q));
endmodule

// File: rtl/almost_flag_fifo.sv
`timescale 1ns/1ps
module almost_flag_fifo #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic [AW:0]   full_ofs,
  input  logic [AW:0]   empty_ofs,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          paf_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          pae_n
);
  localparam int PW    = AW + 2;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wr_gray, wr_gray_s, cons_gray, cons_gray_s, mem_gray, mem_gray_s;
  logic [AW-1:0] wr_addr, rd_addr;
  logic          wr_take, load;
  logic [DW-1:0] store [DEPTH];

  afl_wside #(.AW(AW), .PW(PW)) u_wside (
    .clk(wclk), .rst_n(rst_n), .mode_sel(fwft_sel), .wr_en(wr_en),
    .full_ofs(full_ofs), .cons_gray_s(cons_gray_s), .mem_gray_s(mem_gray_s),
    .wr_gray(wr_gray), .wr_addr(wr_addr), .wr_take(wr_take),
    .full(full), .paf_n(paf_n));

  afl_rside #(.AW(AW), .PW(PW)) u_rside (
    .clk(rclk), .rst_n(rst_n), .mode_sel(fwft_sel), .rd_en(rd_en),
    .empty_ofs(empty_ofs), .wr_gray_s(wr_gray_s), .cons_gray(cons_gray),
    .mem_gray(mem_gray), .rd_addr(rd_addr), .load(load),
    .rd_valid(rd_valid), .empty(empty), .pae_n(pae_n));

  afl_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));

  afl_sync #(.W(2*PW), .STAGES(SYNC)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d({cons_gray, mem_gray}),
    .q({cons_gray_s, mem_gray_s}));

  always_ff @(posedge wclk) begin
    if (wr_take) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge rclk) begin
    if (load) rd_data <= store[rd_addr];
  end
endmodule

// File: tb/sim_almost_flag_fifo.sv
`timescale 1ns/1ps
module sim_almost_flag_fifo;
  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, fwft_sel = 1'b0;
  logic [4:0] full_ofs = '0, empty_ofs = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic       full, paf_n, rd_valid, empty, pae_n;

  int n_chk = 0, n_bad = 0;
  int f, m, n, D, cnt;
  int q_model[$];

  always #2 wclk = ~wclk;   // 250 MHz write clock
  always #3 rclk = ~rclk;

  almost_flag_fifo #(.DW(8), .AW(4), .SYNC(2)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
    .full_ofs(full_ofs), .empty_ofs(empty_ofs), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .paf_n(paf_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(empty), .pae_n(pae_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d m %0d n %0d level %0d)",
               tag, act, exp, f, m, n, cnt);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic check_all();
    chk("R2 paf_n at settled level", paf_n, (cnt + m >= D) ? 0 : 1);
    chk("R3 pae_n at settled level", pae_n, (cnt <= n + f) ? 0 : 1);
    chk("R6 full at settled level", full, (cnt >= D) ? 1 : 0);
    chk("R6 empty at settled level", empty, (cnt == 0) ? 1 : 0);
    if (f == 1) chk("R7 head word present", rd_valid, (cnt > 0) ? 1 : 0);
    else        chk("R7 valid pulse ended", rd_valid, 0);
    if (f == 1 && cnt > 0) chk("R7 head word value", rd_data, q_model[0]);
  endtask

  task automatic do_reset(input int mode);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; fwft_sel = (mode != 0);
    repeat (3) @(negedge wclk);
    chk("R1 paf_n in reset", paf_n, 1);
    chk("R1 pae_n in reset", pae_n, 0);
    chk("R1 full in reset", full, 0);
    chk("R1 empty in reset", empty, 1);
    chk("R1 rd_valid in reset", rd_valid, 0);
    @(negedge wclk) rst_n = 1'b1;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    cnt = 0;
    q_model.delete();
  endtask

  task automatic push(input logic [7:0] d);
    bit pae_was_low;
    pae_was_low = (pae_n == 1'b0);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
    cnt++;
    q_model.push_back(int'(d));
    if (cnt + m >= D) chk("R4 paf_n low on the write edge", paf_n, 0);
    if (cnt >= D)     chk("R6 full on the write edge", full, 1);
    if (pae_was_low && cnt > n + f) begin
      int k = 0;
      do begin @(negedge rclk); k++; end while (pae_n == 1'b0 && k < 20);
      chk("R5 pae_n released within 5 read cycles", (k <= 5) ? 1 : 0, 1);
    end
  endtask

  task automatic pop();
    bit paf_was_low;
    int exp_d;
    paf_was_low = (paf_n == 1'b0);
    exp_d = q_model.pop_front();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    cnt--;
    if (f == 0) begin
      chk("R7 standard read data", rd_data, exp_d);
      chk("R7 standard valid pulse", rd_valid, 1);
    end
    if (cnt <= n + f) chk("R4 pae_n low on the read edge", pae_n, 0);
    if (cnt == 0)     chk("R6 empty on the read edge", empty, 1);
    if (paf_was_low && cnt + m < D) begin
      int k = 0;
      do begin @(negedge wclk); k++; end while (paf_n == 1'b0 && k < 20);
      chk("R5 paf_n released within 5 write cycles", (k <= 5) ? 1 : 0, 1);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    for (int cfg = 0; cfg < 6; cfg++) begin
      f = cfg / 3;
      case (cfg % 3)
        0:       begin m = 1; n = 0;  end
        1:       begin m = 3; n = 2;  end
        default: begin m = 0; n = 15; end
      endcase
      D = 16 + f;
      full_ofs = 5'(m);
      empty_ofs = 5'(n);
      do_reset(f);
      fwft_sel = (f == 0);        // R8: pin flipped after capture
      settle();
      check_all();
      // R6: read request with nothing held
      @(negedge rclk); rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      chk("R6 read on empty delivers nothing", rd_valid, 0);
      settle();
      check_all();
      for (int i = 0; i < D; i++) begin
        push(8'(cfg * 37 + i * 11 + 5));
        settle();
        check_all();
      end
      chk("R8 capacity follows captured mode", full, 1);
      // R6: write request while full must not store
      @(negedge wclk); wr_en = 1'b1; wr_data = 8'hA5;
      @(negedge wclk); wr_en = 1'b0;
      settle();
      check_all();
      while (cnt > 0) begin
        pop();
        settle();
        check_all();
      end
      if (cfg % 3 == 0) begin
        // R7: back-to-back writes keep order
        for (int i = 0; i < 10; i++) begin
          @(negedge wclk); wr_en = 1'b1; wr_data = 8'(i * 7 + cfg);
          q_model.push_back(i * 7 + cfg);
        end
        @(negedge wclk); wr_en = 1'b0;
        cnt = 10;
        settle();
        check_all();
        while (cnt > 0) begin
          pop();
          settle();
          check_all();
        end
      end
    end
    summary();
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    summary();
  end
endmodule